// File: doc/BRIEF.md
# Serial Shift Interface with Busy Control

This block is a byte-wide synchronous serial port built around one shift register. It has a serial data input, a serial data output and a shift clock. In master mode the block makes the shift clock itself from the system clock. A 2-bit code picks one of three periods. In slave mode the block follows a shift clock supplied from outside. That clock is brought into the system clock domain through a two-flop synchronizer, and its edges are detected there.

Software loads the register in parallel while the port is idle and then raises a start strobe, which sets the busy flag. Eight bits then move, most significant bit first. The shift clock idles low. Output data changes after each falling edge of the shift clock, and input data is captured on each rising edge into the least significant bit. After the eighth bit, hardware clears busy and, if the interrupt is enabled, pulses the completion interrupt. Software may clear busy early with a stop strobe. The bits already exchanged then stay in the register, and no interrupt is raised. The register contents can be read in parallel at any time.

Top module: `sio_shift_port`

## Requirements
- R1: After reset, busy_o, irq_o, sck_o, so_o, sck_oe_o, so_oe_o are 0 and rd_data_o is 0.
- R2: While en_i is 0, so_oe_o and sck_oe_o are 0 one cycle later, start strobes are ignored (busy_o stays 0) and no shift clock pulse appears.
- R3: In master mode (master_i=1) the sck_o period in system clocks follows rate_i: 2'b00 gives 2, 2'b01 gives 4, 2'b10 and 2'b11 give 8. sck_o is low whenever no transfer is running.
- R4: Bits leave on so_o MSB first. so_o holds its value while the shift clock is high and changes only after a falling edge. Bits from si_i are captured on rising edges into bit 0, so after a full transfer rd_data_o equals the eight received bits in arrival order (first bit in bit 7).
- R5: Each transfer makes exactly 8 shift clock pulses. busy_o clears together with the eighth falling edge.
- R6: When irq_en_i is 1, irq_o is a one-cycle pulse in the cycle busy_o falls at the end of a complete transfer. When irq_en_i is 0, no pulse occurs.
- R7: A busy_clr_i strobe during a transfer clears busy_o at once. It stops further pulses and raises no interrupt. rd_data_o then holds the loaded byte shifted left by the number of pulses made, with the received bits filling the low end.
- R8: In slave mode (master_i=0) the block drives no clock (sck_o=0, sck_oe_o=0). It shifts on the synchronized edges of sck_i and completes after 8 external pulses. Pulses arriving while not busy change nothing.
- R9: load_i copies load_data_i into the register only while busy_o is 0. A load during a transfer is ignored, and the remaining bits on so_o are those of the originally loaded byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; one cycle is one instruction cycle |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Serial function enable |
| master_i | input | 1 | 1: internal shift clock (master); 0: external (slave) |
| rate_i | input | 2 | Master shift clock period select |
| irq_en_i | input | 1 | Completion interrupt enable |
| busy_set_i | input | 1 | Start strobe, sets busy |
| busy_clr_i | input | 1 | Stop strobe, clears busy early |
| load_i | input | 1 | Parallel load strobe |
| load_data_i | input | 8 | Parallel load value |
| rd_data_o | output | 8 | Shift register contents |
| busy_o | output | 1 | Transfer in progress |
| irq_o | output | 1 | Completion interrupt pulse |
| si_i | input | 1 | Serial data in |
| sck_i | input | 1 | External shift clock (slave) |
| sck_o | output | 1 | Generated shift clock (master) |
| sck_oe_o | output | 1 | Drive enable for sck_o |
| so_o | output | 1 | Serial data out |
| so_oe_o | output | 1 | Drive enable for so_o |

## Verification
The properties assume that the external clock in slave mode runs slower than a quarter of the system clock rate, that si_i is stable around each rising shift edge, and that rate_i stays fixed during a transfer. The bench holds each external clock phase for eight system clocks. It changes si_i only after a detected falling edge. It loads the register before each start, except for one deliberate load during a transfer that checks the load is rejected. The stop strobe is issued only after a counted rising edge, so the expected partial contents are known.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam int MAX_PERIOD = 8;
  localparam int DIV_W = $clog2(MAX_PERIOD);
  typedef logic [DIV_W-1:0] div_t;

  // last count of one shift clock period for a rate code
  function automatic div_t period_last(input logic [1:0] code);
    case (code)
      2'b00:   period_last = div_t'(1);
      2'b01:   period_last = div_t'(3);
      default: period_last = div_t'(7);
    endcase
  endfunction

  // count at which the shift clock rises (end of the low half)
  function automatic div_t half_last(input logic [1:0] code);
    case (code)
      2'b00:   half_last = div_t'(0);
      2'b01:   half_last = div_t'(1);
      default: half_last = div_t'(3);
    endcase
  endfunction
endpackage

// File: rtl/sio_clkgen.sv
module sio_clkgen
  import sio_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic [1:0] rate,
  output logic       rise,
  output logic       fall,
  output logic       sck
);
  div_t cnt;

  assign rise = run && (cnt == half_last(rate));
  assign fall = run && (cnt >= period_last(rate));

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      sck <= 1'b0;
    end else begin
      cnt <= fall ? '0 : cnt + div_t'(1);
      if (rise)      sck <= 1'b1;
      else if (fall) sck <= 1'b0;
    end
  end
endmodule

// File: rtl/sio_edge_sync.sv
module sio_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sck_in,
  input  logic si_in,
  output logic rise,
  output logic fall,
  output logic si_bit
);
  logic [STAGES:0]   sck_s;
  logic [STAGES-1:0] si_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_s <= '0;
      si_s  <= '0;
    end else begin
      sck_s <= {sck_s[STAGES-1:0], sck_in};
      si_s  <= {si_s[STAGES-2:0], si_in};
    end
  end

  assign rise   = sck_s[STAGES-1] && !sck_s[STAGES];
  assign fall   = !sck_s[STAGES-1] && sck_s[STAGES];
  assign si_bit = si_s[STAGES-1];
endmodule

// File: rtl/sio_shifter.sv
module sio_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         start,
  input  logic         abort,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         rise,
  input  logic         fall,
  input  logic         si_bit,
  input  logic         irq_en,
  output logic [W-1:0] sr,
  output logic         busy,
  output logic         so,
  output logic         irq
);
  localparam int CNT_W = $clog2(W);
  logic [CNT_W-1:0] bits;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr   <= '0;
      busy <= 1'b0;
      so   <= 1'b0;
      irq  <= 1'b0;
      bits <= '0;
    end else begin
      irq <= 1'b0;
      if (busy) begin
        if (!en || abort) begin
          busy <= 1'b0;
        end else begin
          if (rise) sr <= {sr[W-2:0], si_bit};
          if (fall) begin
            so <= sr[W-1];
            if (bits == CNT_W'(W-1)) begin
              busy <= 1'b0;
              irq  <= irq_en;
            end else begin
              bits <= bits + CNT_W'(1);
            end
          end
        end
      end else if (start && en && !abort) begin
        busy <= 1'b1;
        bits <= '0;
        so   <= sr[W-1];
      end else if (load) begin
        sr <= load_data;
        so <= load_data[W-1];
      end
    end
  end
endmodule

// File: rtl/sio_shift_port.sv
module sio_shift_port #(
  parameter int W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en_i,
  input  logic         master_i,
  input  logic [1:0]   rate_i,
  input  logic         irq_en_i,
  input  logic         busy_set_i,
  input  logic         busy_clr_i,
  input  logic         load_i,
  input  logic [W-1:0] load_data_i,
  output logic [W-1:0] rd_data_o,
  output logic         busy_o,
  output logic         irq_o,
  input  logic         si_i,
  input  logic         sck_i,
  output logic         sck_o,
  output logic         sck_oe_o,
  output logic         so_o,
  output logic         so_oe_o
);
  logic m_rise, m_fall, s_rise, s_fall, s_si;
  logic run, rise, fall, si_bit;

  assign run    = en_i && master_i && busy_o && !busy_clr_i;
  assign rise   = master_i ? m_rise : s_rise;
  assign fall   = master_i ? m_fall : s_fall;
  assign si_bit = master_i ? si_i : s_si;

  sio_clkgen u_clkgen (
    .clk(clk), .rst(rst), .run(run), .rate(rate_i),
    .rise(m_rise), .fall(m_fall), .sck(sck_o)
  );

  sio_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .sck_in(sck_i), .si_in(si_i),
    .rise(s_rise), .fall(s_fall), .si_bit(s_si)
  );

  sio_shifter #(.W(W)) u_shift (
    .clk(clk), .rst(rst), .en(en_i), .start(busy_set_i), .abort(busy_clr_i),
    .load(load_i), .load_data(load_data_i), .rise(rise), .fall(fall),
    .si_bit(si_bit), .irq_en(irq_en_i), .sr(rd_data_o), .busy(busy_o),
    .so(so_o), .irq(irq_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_oe_o <= 1'b0;
      so_oe_o  <= 1'b0;
    end else begin
      sck_oe_o <= en_i && master_i;
      so_oe_o  <= en_i;
    end
  end
endmodule

// File: rtl/sio_shift_port_chk.sv
module sio_shift_port_chk (
  input logic clk,
  input logic rst,
  input logic en_i,
  input logic master_i,
  input logic busy_o,
  input logic irq_o,
  input logic sck_o,
  input logic so_o,
  input logic so_oe_o,
  input logic sck_oe_o
);
  AST_SCK_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
    !$past(busy_o) |-> !sck_o);  // R5

  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    irq_o |=> !irq_o);  // R6

  AST_IRQ_AT_END: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $fell(busy_o));  // R6

  AST_OFF_UNDRIVEN: assert property (@(posedge clk) disable iff (rst)
    !$past(en_i) |-> (!so_oe_o && !sck_oe_o));  // R2

  AST_SO_HOLD_HIGH: assert property (@(posedge clk) disable iff (rst)
    (sck_o && $past(sck_o)) |-> $stable(so_o));  // R4

  AST_SLAVE_NO_SCK: assert property (@(posedge clk) disable iff (rst)
    !$past(master_i) |-> !sck_o);  // R8
endmodule

bind sio_shift_port sio_shift_port_chk u_chk (
  .clk(clk), .rst(rst), .en_i(en_i), .master_i(master_i), .busy_o(busy_o),
  .irq_o(irq_o), .sck_o(sck_o), .so_o(so_o), .so_oe_o(so_oe_o),
  .sck_oe_o(sck_oe_o)
);

// File: tb/tb_sio_shift_port.sv
`timescale 1ns/1ps
module tb_sio_shift_port;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en_i = 1'b0, master_i = 1'b1, irq_en_i = 1'b0;
  logic [1:0] rate_i = 2'b00;
  logic busy_set_i = 1'b0, busy_clr_i = 1'b0, load_i = 1'b0;
  logic [7:0] load_data_i = '0;
  logic [7:0] rd_data_o;
  logic busy_o, irq_o, sck_o, sck_oe_o, so_o, so_oe_o;
  logic sck_i = 1'b0;
  logic [7:0] si_shreg = '0;
  wire si_i = si_shreg[7];

  int total = 0, bad = 0;
  int cyc = 0, rises = 0, last_rise = 0, per_exp = 0, irq_cnt = 0;
  logic prev_line = 1'b0;
  bit exp_q[$];

  always #2.5 clk = ~clk;

  sio_shift_port dut (
    .clk(clk), .rst(rst), .en_i(en_i), .master_i(master_i), .rate_i(rate_i),
    .irq_en_i(irq_en_i), .busy_set_i(busy_set_i), .busy_clr_i(busy_clr_i),
    .load_i(load_i), .load_data_i(load_data_i), .rd_data_o(rd_data_o),
    .busy_o(busy_o), .irq_o(irq_o), .si_i(si_i), .sck_i(sck_i),
    .sck_o(sck_o), .sck_oe_o(sck_oe_o), .so_o(so_o), .so_oe_o(so_oe_o)
  );

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // monitor: scoreboard side, sampled on falling clock edges
  always @(negedge clk) begin
    logic line;
    cyc++;
    line = master_i ? sck_o : sck_i;
    if (line && !prev_line) begin
      if (exp_q.size() > 0) begin
        bit eb;
        eb = exp_q.pop_front();
        chk(so_o == eb, "R4 serial out bit", so_o, eb);
      end
      if (master_i && rises > 0 && per_exp != 0)
        chk(cyc - last_rise == per_exp, "R3 shift clock period", cyc - last_rise, per_exp);
      last_rise = cyc;
      rises++;
    end
    if (!line && prev_line) si_shreg = {si_shreg[6:0], 1'b0};
    if (irq_o) irq_cnt++;
    prev_line = line;
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic prep(input logic [7:0] tx, input logic [7:0] rx);
    load_i = 1'b1; load_data_i = tx;
    tick(1);
    load_i = 1'b0;
    si_shreg = rx;
    rises = 0;
    for (int i = 0; i < 8; i++) exp_q.push_back(tx[7-i]);
    busy_set_i = 1'b1;
    tick(1);
    busy_set_i = 1'b0;
  endtask

  task automatic master_xfer(input logic [1:0] rate, input logic [7:0] tx,
                             input logic [7:0] rx, input bit ie,
                             input int abort_n, input bit load_mid);
    int irq0;
    logic [7:0] exp_rd;
    tick(1);
    master_i = 1'b1; rate_i = rate; irq_en_i = ie;
    per_exp = (rate == 2'b00) ? 2 : (rate == 2'b01) ? 4 : 8;
    irq0 = irq_cnt;
    prep(tx, rx);
    if (abort_n > 0) begin
      while (rises < abort_n) tick(1);
      busy_clr_i = 1'b1;
      tick(1);
      busy_clr_i = 1'b0;
      chk(busy_o == 1'b0, "R7 busy after stop", busy_o, 0);
      tick(30);
      exp_rd = (tx << abort_n) | (rx >> (8 - abort_n));
      chk(rises == abort_n, "R7 pulses after stop", rises, abort_n);
      chk(irq_cnt == irq0, "R7 no interrupt on stop", irq_cnt - irq0, 0);
      chk(rd_data_o == exp_rd, "R7 partial contents", rd_data_o, exp_rd);
      exp_q.delete();
    end else begin
      if (load_mid) begin
        while (rises < 2) tick(1);
        load_i = 1'b1; load_data_i = 8'hFF;
        tick(1);
        load_i = 1'b0;
      end
      while (busy_o) tick(1);
      tick(20);
      chk(rises == 8, "R5 pulse count", rises, 8);
      chk(rd_data_o == rx, "R4 received byte", rd_data_o, rx);
      chk(irq_cnt - irq0 == (ie ? 1 : 0), "R6 interrupt count", irq_cnt - irq0, ie ? 1 : 0);
      chk(exp_q.size() == 0, load_mid ? "R9 bits after ignored load" : "R4 all bits seen",
          exp_q.size(), 0);
      chk(sck_o == 1'b0, "R3 clock idles low", sck_o, 0);
    end
  endtask

  task automatic ext_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      tick(8); sck_i = 1'b1;
      tick(8); sck_i = 1'b0;
    end
  endtask

  initial begin
    tick(4);
    rst = 1'b0;
    tick(1);
    chk(busy_o == 0 && irq_o == 0 && sck_o == 0 && so_o == 0, "R1 flags after reset",
        {busy_o, irq_o, sck_o, so_o}, 0);
    chk(rd_data_o == 8'h00, "R1 register after reset", rd_data_o, 0);
    chk(sck_oe_o == 0 && so_oe_o == 0, "R1 drive enables after reset", {sck_oe_o, so_oe_o}, 0);

    // R2: disabled, start ignored
    busy_set_i = 1'b1; tick(1); busy_set_i = 1'b0;
    tick(10);
    chk(busy_o == 0, "R2 start ignored while off", busy_o, 0);
    chk(rises == 0 && sck_o == 0, "R2 no clock while off", rises, 0);

    en_i = 1'b1;
    tick(2);
    chk(so_oe_o == 1 && sck_oe_o == 1, "R2 drive enables when on", {sck_oe_o, so_oe_o}, 3);

    master_xfer(2'b00, 8'hA5, 8'h3C, 1'b1, 0, 1'b0);
    master_xfer(2'b01, 8'h5A, 8'hC3, 1'b1, 0, 1'b0);
    master_xfer(2'b10, 8'h0F, 8'hF0, 1'b0, 0, 1'b0);
    master_xfer(2'b11, 8'h81, 8'h7E, 1'b1, 0, 1'b1);
    master_xfer(2'b10, 8'hA5, 8'h3C, 1'b1, 3, 1'b0);
    master_xfer(2'b00, 8'h96, 8'h69, 1'b1, 5, 1'b0);

    // R8: slave transfer
    begin
      int irq0;
      master_i = 1'b0; irq_en_i = 1'b1; per_exp = 0;
      tick(2);
      chk(sck_oe_o == 0, "R8 clock not driven in slave", sck_oe_o, 0);
      irq0 = irq_cnt;
      prep(8'hC6, 8'h5B);
      ext_pulses(8);
      tick(10);
      chk(busy_o == 0, "R8 slave completes", busy_o, 0);
      chk(rd_data_o == 8'h5B, "R8 slave received byte", rd_data_o, 8'h5B);
      chk(irq_cnt - irq0 == 1, "R6 slave interrupt", irq_cnt - irq0, 1);
      chk(exp_q.size() == 0, "R8 slave bits seen", exp_q.size(), 0);
      si_shreg = 8'hFF;
      ext_pulses(2);
      tick(10);
      chk(rd_data_o == 8'h5B, "R8 pulses ignored when idle", rd_data_o, 8'h5B);
      chk(irq_cnt - irq0 == 1 && busy_o == 0, "R8 no restart by pulses", irq_cnt - irq0, 1);
    end

    en_i = 1'b0;
    tick(2);
    chk(so_oe_o == 0 && sck_oe_o == 0, "R2 drive enables off", {sck_oe_o, so_oe_o}, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule